// File: doc/BRIEF.md
# ATM Cell Header Error Corrector

This block sits on the receive path after cell delineation. It inspects the five-byte header of every 53-byte ATM cell that arrives as a byte stream. The header check byte is recomputed over the first four header bytes and compared with the fifth. A nonzero syndrome means the header is damaged. The block then applies a policy with two modes. In the correcting mode, a header with a single flipped bit is repaired in flight. In the detecting mode, any damaged cell is marked for dropping.

The mode changes with recent error history. Any damaged header seen while correcting moves the block to detecting. A run of clean headers moves it back. A separate run counter tracks consecutive damaged headers. When that run reaches its limit, the block sends a one-cycle pulse to the delineation logic, which then starts searching again.

Cells leave the block as a byte stream. The stream lags the input by exactly five accepted bytes, which leaves room to substitute the repaired header bytes. Each output cell carries a keep flag. Downstream logic acts on that flag. The block also produces one-cycle status pulses for corrected, dropped and retained cells.

Top module: `atm_hec_corrector`

## Requirements
- R1: After reset the block is in correcting mode. `out_valid`, every status pulse and `lod_pulse` are 0. The first damaged cell after reset is handled by the correcting-mode rules.
- R2: The check byte is a CRC-8 with generator x^8+x^2+x+1 and zero start value. It runs over header bytes 0..3, most significant bit first, and is compared with header byte 4. A cell whose syndrome is zero leaves with keep=1 and an unchanged header, and raises no status pulse.
- R3: In correcting mode, a header with exactly one flipped bit (any of the 40 positions) leaves repaired with keep=1. `st_corrected` pulses and the block moves to detecting mode.
- R4: In correcting mode, with `cfg_ctrl[0]`=0, a header whose syndrome matches no single-bit pattern leaves with keep=0. `st_discarded` pulses and the block moves to detecting mode.
- R5: In correcting mode, with `cfg_ctrl[0]`=1, such a multi-bit header leaves with keep=1 and its bytes unmodified. `st_retained` pulses and the block moves to detecting mode.
- R6: In detecting mode, every damaged cell leaves with keep=0, whether its error is single-bit or multi-bit and whatever `cfg_ctrl[0]` holds. No repair is made, `st_discarded` pulses, and the mode stays detecting.
- R7: Detecting mode returns to correcting mode after GOOD_RUN consecutive clean cells. A damaged cell restarts that count.
- R8: After BAD_RUN consecutive cells with a nonzero syndrome, `lod_pulse` is high for one cycle and the run restarts. Repaired cells count toward the run. A clean cell clears the run.
- R9: When `cfg_ctrl[1]`=1, the recomputed CRC is XORed with 0x55 before the comparison. A cell that carries the plain CRC is then treated as a multi-bit error.
- R10: Output bytes equal the input bytes delayed by exactly five accepted bytes (bytes with `in_valid`=1), whatever idle cycles lie between them. `out_valid` rises only in the cycle after an accepted byte. `out_soc` marks byte 0. `out_keep` is valid from the `out_soc` byte and is held for the whole cell. Payload bytes are never altered.
- R11: Each cell raises at most one of `st_corrected`, `st_discarded` and `st_retained`. The pulse lasts one cycle and follows the clock edge that accepts header byte 4. Byte 0 of a cell is the byte accepted with `in_soc`=1. No decision is made before the first `in_soc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte strobe |
| in_soc | input | 1 | Marks byte 0 of a cell |
| in_data | input | 8 | Input cell byte |
| cfg_ctrl | input | 2 | Bit 0: retain multi-bit cells in correcting mode; bit 1: coset adjustment |
| out_valid | output | 1 | Output byte strobe |
| out_soc | output | 1 | Marks byte 0 of an output cell |
| out_data | output | 8 | Output cell byte, header repaired where allowed |
| out_keep | output | 1 | 1 = pass the cell on, 0 = drop it |
| st_corrected | output | 1 | One-cycle pulse: header repaired |
| st_discarded | output | 1 | One-cycle pulse: cell marked for dropping |
| st_retained | output | 1 | One-cycle pulse: multi-bit cell kept |
| lod_pulse | output | 1 | One-cycle pulse: damaged-header run reached its limit |

## Verification
The bench builds the block with GOOD_RUN=3 and BAD_RUN=4 instead of the defaults of 6 and 7, and keeps CELL_BYTES at 53. The short runs let a handful of cells reach both boundaries. The bench can then show that one clean cell too few leaves the block detecting, and that three damaged cells separated by a clean one raise no loss pulse. Because the two limits differ, a design that swaps the two counters fails a check. Idle gaps inside cells exercise the byte-counted delay.

// File: rtl/atm_hec_pkg.sv
package atm_hec_pkg;

   localparam int HDR_BYTES = 5;
   localparam int HDR_BITS  = 8 * HDR_BYTES;

   typedef enum logic {
      MODE_CORRECT = 1'b0,
      MODE_DETECT  = 1'b1
   } hec_mode_e;

   // CRC-8, generator x^8+x^2+x+1, zero start, 32 data bits MSB first
   function automatic logic [7:0] crc8_msb(input logic [31:0] d);
      logic [7:0] c;
      logic       fb;
      c = 8'h00;
      for (int i = 31; i >= 0; i--) begin
         fb = c[7] ^ d[i];
         c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
      return c;
   endfunction

   // syndrome produced by a lone flipped bit at header position pos (39 = byte 0 MSB)
   function automatic logic [7:0] single_syn(input int pos);
      logic [HDR_BITS-1:0] e;
      e      = '0;
      e[pos] = 1'b1;
      return crc8_msb(e[HDR_BITS-1:8]) ^ e[7:0];
   endfunction

endpackage

// File: rtl/atm_hec_syndrome.sv
module atm_hec_syndrome
   import atm_hec_pkg::*;
#(
   parameter logic [7:0] COSET_WORD = 8'h55
) (
   input  logic [HDR_BITS-1:0] hdr,
   input  logic                coset_en,
   output logic                syn_nz,
   output logic                single,
   output logic [HDR_BITS-1:0] hit
);

   logic [7:0] syn;

   assign syn    = crc8_msb(hdr[HDR_BITS-1:8]) ^ hdr[7:0] ^ (coset_en ? COSET_WORD : 8'h00);
   assign syn_nz = |syn;

   for (genvar k = 0; k < HDR_BITS; k++) begin : g_pos
      localparam logic [7:0] SK = single_syn(k);
      assign hit[k] = (syn == SK);
   end

   assign single = |hit;

endmodule

// File: rtl/atm_hec_policy.sv
module atm_hec_policy
   import atm_hec_pkg::*;
#(
   parameter int GOOD_RUN = 6,
   parameter int BAD_RUN  = 7,
   localparam int GW = $clog2(GOOD_RUN + 1),
   localparam int BW = $clog2(BAD_RUN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          decide,
   input  logic          err,
   input  logic          single,
   input  logic          ignore_multi,
   output logic          apply_fix,
   output logic          keep,
   output logic          st_corrected,
   output logic          st_discarded,
   output logic          st_retained,
   output logic          lod_pulse,
   output logic          mode_det,
   output logic [GW-1:0] good_cnt,
   output logic [BW-1:0] bad_cnt
);

   if (GOOD_RUN < 1) begin : g_bad_good
      $error("GOOD_RUN must be at least 1");
   end
   if (BAD_RUN < 1) begin : g_bad_bad
      $error("BAD_RUN must be at least 1");
   end

   hec_mode_e mode_q;
   logic      in_corr, fix_now, retain_now, good_last, bad_last;

   assign in_corr    = (mode_q == MODE_CORRECT);
   assign fix_now    = decide & err & single & in_corr;
   assign retain_now = decide & err & ~single & in_corr & ignore_multi;
   assign apply_fix  = fix_now;
   assign keep       = ~err | (in_corr & (single | ignore_multi));
   assign good_last  = (good_cnt == GW'(GOOD_RUN - 1));
   assign bad_last   = (bad_cnt == BW'(BAD_RUN - 1));
   assign mode_det   = (mode_q == MODE_DETECT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q       <= MODE_CORRECT;
         good_cnt     <= '0;
         bad_cnt      <= '0;
         st_corrected <= 1'b0;
         st_discarded <= 1'b0;
         st_retained  <= 1'b0;
         lod_pulse    <= 1'b0;
      end else begin
         st_corrected <= fix_now;
         st_retained  <= retain_now;
         st_discarded <= decide & err & ~fix_now & ~retain_now;
         lod_pulse    <= 1'b0;
         if (decide) begin
            if (err) begin
               mode_q   <= MODE_DETECT;
               good_cnt <= '0;
               if (bad_last) begin
                  bad_cnt   <= '0;
                  lod_pulse <= 1'b1;
               end else begin
                  bad_cnt <= bad_cnt + 1'b1;
               end
            end else begin
               bad_cnt <= '0;
               if (mode_q == MODE_DETECT) begin
                  if (good_last) begin
                     mode_q   <= MODE_CORRECT;
                     good_cnt <= '0;
                  end else begin
                     good_cnt <= good_cnt + 1'b1;
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/atm_hec_delay.sv
module atm_hec_delay
   import atm_hec_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic                in_soc,
   input  logic [7:0]          in_data,
   input  logic                decide,
   input  logic                keep,
   input  logic [HDR_BITS-1:0] fix,
   output logic [HDR_BITS-1:0] hdr_tap,
   output logic                out_valid,
   output logic                out_soc,
   output logic [7:0]          out_data,
   output logic                out_keep
);

   localparam int LAST = HDR_BYTES - 1;

   logic [7:0]           sr_data [HDR_BYTES];
   logic [HDR_BYTES-1:0] sr_soc, sr_vld;
   logic                 pend_keep;

   assign hdr_tap[7:0] = in_data;
   for (genvar i = 0; i < HDR_BYTES - 1; i++) begin : g_tap
      assign hdr_tap[8*i+15 -: 8] = sr_data[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < HDR_BYTES; i++) sr_data[i] <= 8'h00;
         sr_soc    <= '0;
         sr_vld    <= '0;
         pend_keep <= 1'b0;
         out_valid <= 1'b0;
         out_soc   <= 1'b0;
         out_data  <= 8'h00;
         out_keep  <= 1'b0;
      end else begin
         if (decide) pend_keep <= keep;
         if (in_valid) begin
            sr_data[0] <= in_data ^ fix[7:0];
            for (int i = 1; i < HDR_BYTES; i++)
               sr_data[i] <= sr_data[i-1] ^ fix[8*i+7 -: 8];
            sr_soc    <= {sr_soc[LAST-1:0], in_soc};
            sr_vld    <= {sr_vld[LAST-1:0], 1'b1};
            out_valid <= sr_vld[LAST];
            out_soc   <= sr_vld[LAST] & sr_soc[LAST];
            out_data  <= sr_data[LAST];
            if (sr_vld[LAST] && sr_soc[LAST]) out_keep <= pend_keep;
         end else begin
            out_valid <= 1'b0;
            out_soc   <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/atm_hec_corrector.sv
module atm_hec_corrector
   import atm_hec_pkg::*;
#(
   parameter int         CELL_BYTES = 53,
   parameter int         GOOD_RUN   = 6,
   parameter int         BAD_RUN    = 7,
   parameter logic [7:0] COSET_WORD = 8'h55
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic       in_soc,
   input  logic [7:0] in_data,
   input  logic [1:0] cfg_ctrl,
   output logic       out_valid,
   output logic       out_soc,
   output logic [7:0] out_data,
   output logic       out_keep,
   output logic       st_corrected,
   output logic       st_discarded,
   output logic       st_retained,
   output logic       lod_pulse
);

   localparam int PW = $clog2(CELL_BYTES + 1);
   localparam int GW = $clog2(GOOD_RUN + 1);
   localparam int BW = $clog2(BAD_RUN + 1);

   if (CELL_BYTES <= HDR_BYTES) begin : g_bad_cell
      $error("CELL_BYTES must exceed the header length");
   end

   logic [PW-1:0]       pos_q, cur_pos;
   logic                decide, syn_nz, single, apply_fix, keep, mode_det;
   logic [HDR_BITS-1:0] hdr_tap, hit, fix_eff;
   logic [GW-1:0]       good_cnt;
   logic [BW-1:0]       bad_cnt;

   assign cur_pos = in_soc ? '0 : pos_q;
   assign decide  = in_valid && (cur_pos == PW'(HDR_BYTES - 1));
   assign fix_eff = apply_fix ? hit : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) pos_q <= PW'(CELL_BYTES);
      else if (in_valid && cur_pos != PW'(CELL_BYTES)) pos_q <= cur_pos + 1'b1;
      else if (in_valid) pos_q <= cur_pos;
   end

   atm_hec_syndrome #(.COSET_WORD(COSET_WORD)) u_syn (
      .hdr      (hdr_tap),
      .coset_en (cfg_ctrl[1]),
      .syn_nz   (syn_nz),
      .single   (single),
      .hit      (hit)
   );

   atm_hec_policy #(.GOOD_RUN(GOOD_RUN), .BAD_RUN(BAD_RUN)) u_policy (
      .clk          (clk),
      .rst_n        (rst_n),
      .decide       (decide),
      .err          (syn_nz),
      .single       (single),
      .ignore_multi (cfg_ctrl[0]),
      .apply_fix    (apply_fix),
      .keep         (keep),
      .st_corrected (st_corrected),
      .st_discarded (st_discarded),
      .st_retained  (st_retained),
      .lod_pulse    (lod_pulse),
      .mode_det     (mode_det),
      .good_cnt     (good_cnt),
      .bad_cnt      (bad_cnt)
   );

   atm_hec_delay u_delay (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_soc    (in_soc),
      .in_data   (in_data),
      .decide    (decide),
      .keep      (keep),
      .fix       (fix_eff),
      .hdr_tap   (hdr_tap),
      .out_valid (out_valid),
      .out_soc   (out_soc),
      .out_data  (out_data),
      .out_keep  (out_keep)
   );

endmodule

// File: rtl/atm_hec_corrector_chk.sv
module atm_hec_corrector_chk #(
   parameter int GOOD_RUN = 6,
   parameter int BAD_RUN  = 7,
   parameter int GW = $clog2(GOOD_RUN + 1),
   parameter int BW = $clog2(BAD_RUN + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          ignore_multi,
   input logic          out_valid,
   input logic          st_corrected,
   input logic          st_discarded,
   input logic          st_retained,
   input logic          lod_pulse,
   input logic          mode_det,
   input logic [GW-1:0] good_cnt,
   input logic [BW-1:0] bad_cnt
);

   a_r11_one_status: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({st_corrected, st_discarded, st_retained}));

   a_r11_status_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (st_corrected || st_discarded || st_retained || lod_pulse) |-> $past(in_valid));

   a_r3_fix_enters_detect: assert property (@(posedge clk) disable iff (!rst_n)
      st_corrected |-> mode_det);

   a_r6_no_fix_in_detect: assert property (@(posedge clk) disable iff (!rst_n)
      st_corrected |-> !$past(mode_det));

   a_r5_retain_needs_bit0: assert property (@(posedge clk) disable iff (!rst_n)
      st_retained |-> ($past(ignore_multi) && !$past(mode_det)));

   a_r7_good_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
      good_cnt <= GW'(GOOD_RUN - 1));

   a_r7_count_only_detect: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_det |-> (good_cnt == '0));

   a_r8_lod_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
      lod_pulse |-> ($past(bad_cnt) == BW'(BAD_RUN - 1) && bad_cnt == '0));

   a_r10_out_follows_in: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

endmodule

bind atm_hec_corrector atm_hec_corrector_chk #(.GOOD_RUN(GOOD_RUN), .BAD_RUN(BAD_RUN)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .ignore_multi (cfg_ctrl[0]),
   .out_valid    (out_valid),
   .st_corrected (st_corrected),
   .st_discarded (st_discarded),
   .st_retained  (st_retained),
   .lod_pulse    (lod_pulse),
   .mode_det     (mode_det),
   .good_cnt     (good_cnt),
   .bad_cnt      (bad_cnt)
);

// File: tb/atm_hec_corrector_test.sv
module atm_hec_corrector_test;

   localparam int GOOD_RUN = 3;
   localparam int BAD_RUN  = 4;
   localparam int CELL     = 53;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0, in_soc = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic [1:0] cfg_ctrl = 2'b00;
   logic       out_valid, out_soc, out_keep;
   logic [7:0] out_data;
   logic       st_corrected, st_discarded, st_retained, lod_pulse;

   always #5 clk = ~clk;

   atm_hec_corrector #(.CELL_BYTES(CELL), .GOOD_RUN(GOOD_RUN), .BAD_RUN(BAD_RUN)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soc(in_soc), .in_data(in_data),
      .cfg_ctrl(cfg_ctrl), .out_valid(out_valid), .out_soc(out_soc), .out_data(out_data),
      .out_keep(out_keep), .st_corrected(st_corrected), .st_discarded(st_discarded),
      .st_retained(st_retained), .lod_pulse(lod_pulse)
   );

   int  n_run = 0, n_fail = 0;
   bit  done = 1'b0;

   int          ncell, n_cor, n_dis, n_ret, n_lod;
   logic [39:0] o_hdr [40];
   logic        o_keep [40];
   int          o_len [40];
   int          o_sum [40];

   always @(negedge clk) begin
      if (rst_n) begin
         if (st_corrected) n_cor++;
         if (st_discarded) n_dis++;
         if (st_retained)  n_ret++;
         if (lod_pulse)    n_lod++;
         if (out_valid) begin
            if (out_soc && ncell < 40) begin
               o_len[ncell]  = 0;
               o_sum[ncell]  = 0;
               o_hdr[ncell]  = '0;
               o_keep[ncell] = out_keep;
               ncell++;
            end
            if (ncell > 0) begin
               if (o_len[ncell-1] < 5) o_hdr[ncell-1][39-8*o_len[ncell-1] -: 8] = out_data;
               else o_sum[ncell-1] += int'(out_data);
               if (o_keep[ncell-1] != out_keep) o_keep[ncell-1] = 1'bx;
               o_len[ncell-1]++;
            end
         end
      end
   end

   function automatic logic [7:0] tb_crc(input logic [31:0] h);
      logic [7:0] c = 8'h00;
      for (int b = 3; b >= 0; b--) begin
         c ^= h[8*b +: 8];
         for (int s = 0; s < 8; s++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
      end
      return c;
   endfunction

   function automatic logic [39:0] mk_hdr(input logic [31:0] h, input bit cos);
      return {h, tb_crc(h) ^ (cos ? 8'h55 : 8'h00)};
   endfunction

   function automatic int pay_sum(input logic [7:0] seed);
      int s = 0;
      for (int j = 5; j < CELL; j++) s += int'(8'(seed + j));
      return s;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] d, input bit soc);
      @(negedge clk);
      in_valid = 1'b1; in_soc = soc; in_data = d;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0; in_soc = 1'b0;
      end
   endtask

   task automatic send_cell(input logic [39:0] hdr, input logic [7:0] seed, input bit gaps);
      for (int j = 0; j < CELL; j++) begin
         put(j < 5 ? hdr[39-8*j -: 8] : 8'(seed + j), j == 0);
         if (gaps && (j % 7) == 6) idle(1);
      end
   endtask

   task automatic flush();
      for (int j = 0; j < 5; j++) put(8'hA5, 1'b0);
      idle(4);
   endtask

   task automatic do_reset(input logic [1:0] cfg);
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; in_soc = 1'b0; in_data = 8'h00; cfg_ctrl = cfg;
      ncell = 0; n_cor = 0; n_dis = 0; n_ret = 0; n_lod = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic test_reset();
      do_reset(2'b00);
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 0);
      check({st_corrected, st_discarded, st_retained, lod_pulse} == 4'b0, "R1", "pulses after reset",
            64'({st_corrected, st_discarded, st_retained, lod_pulse}), 0);
   endtask

   task automatic test_clean_stream();
      logic [39:0] h [3];
      do_reset(2'b00);
      h[0] = mk_hdr(32'h0012_3450, 0);
      h[1] = mk_hdr(32'hFFFF_FFF0, 0);
      h[2] = mk_hdr(32'h0000_0000, 0);
      for (int c = 0; c < 3; c++) send_cell(h[c], 8'(16 * c + 3), 1'b1);
      flush();
      check(ncell == 3, "R10", "clean cell count", 64'(ncell), 3);
      for (int c = 0; c < 3; c++) begin
         check(o_hdr[c] == h[c], "R2", "clean header", o_hdr[c], h[c]);
         check(o_keep[c] === 1'b1, "R2", "clean keep", 64'(o_keep[c]), 1);
         check(o_len[c] == CELL, "R10", "cell length with gaps", 64'(o_len[c]), CELL);
         check(o_sum[c] == pay_sum(8'(16 * c + 3)), "R10", "payload sum",
               64'(o_sum[c]), 64'(pay_sum(8'(16 * c + 3))));
      end
      check(n_cor + n_dis + n_ret + n_lod == 0, "R2", "no pulses on clean cells",
            64'(n_cor + n_dis + n_ret + n_lod), 0);
   endtask

   task automatic test_single_fix();
      logic [39:0] g;
      do_reset(2'b00);
      g = mk_hdr(32'h0A0B_0C00, 0);
      send_cell(g, 8'h11, 1'b0);
      send_cell(g ^ (40'h1 << 20), 8'h22, 1'b0);
      send_cell(g ^ (40'h1 << 3), 8'h33, 1'b0);
      flush();
      check(o_hdr[1] == g, "R3", "repaired header", o_hdr[1], g);
      check(o_keep[1] === 1'b1, "R3", "repaired keep", 64'(o_keep[1]), 1);
      check(n_cor == 1, "R1", "first error repaired after reset", 64'(n_cor), 1);
      check(o_keep[2] === 1'b0, "R6", "single error in detect dropped", 64'(o_keep[2]), 0);
      check(o_hdr[2] == (g ^ (40'h1 << 3)), "R6", "no repair in detect", o_hdr[2], g ^ (40'h1 << 3));
      check(n_dis == 1 && n_cor + n_dis + n_ret == 2, "R11", "one pulse per errored cell",
            64'(n_cor + n_dis + n_ret), 2);
   endtask

   task automatic test_multi_drop();
      logic [39:0] g;
      do_reset(2'b00);
      g = mk_hdr(32'h1234_5670, 0);
      send_cell(g ^ (40'h1 << 30) ^ (40'h1 << 9), 8'h40, 1'b0);
      send_cell(g ^ (40'h1 << 33), 8'h41, 1'b0);
      flush();
      check(o_keep[0] === 1'b0, "R4", "multi dropped", 64'(o_keep[0]), 0);
      check(o_keep[1] === 1'b0, "R4", "detect after multi", 64'(o_keep[1]), 0);
      check(n_dis == 2 && n_cor == 0, "R4", "dropped count", 64'(n_dis), 2);
   endtask

   task automatic test_multi_keep();
      logic [39:0] g, bad;
      do_reset(2'b01);
      g   = mk_hdr(32'hCAFE_0010, 0);
      bad = g ^ (40'h1 << 38) ^ (40'h1 << 1);
      send_cell(bad, 8'h50, 1'b0);
      send_cell(bad, 8'h51, 1'b0);
      flush();
      check(o_keep[0] === 1'b1, "R5", "multi retained", 64'(o_keep[0]), 1);
      check(o_hdr[0] == bad, "R5", "retained header unchanged", o_hdr[0], bad);
      check(n_ret == 1, "R5", "retained pulse", 64'(n_ret), 1);
      check(o_keep[1] === 1'b0 && n_dis == 1, "R6", "multi in detect dropped despite bit0",
            64'(o_keep[1]), 0);
   endtask

   task automatic test_return_to_correct();
      logic [39:0] g;
      do_reset(2'b00);
      g = mk_hdr(32'h0055_AA00, 0);
      send_cell(g ^ 40'h1, 8'h60, 1'b0);
      for (int i = 0; i < GOOD_RUN - 1; i++) send_cell(g, 8'h61, 1'b0);
      send_cell(g ^ (40'h1 << 15), 8'h62, 1'b0);
      for (int i = 0; i < GOOD_RUN; i++) send_cell(g, 8'h63, 1'b0);
      send_cell(g ^ (40'h1 << 15), 8'h64, 1'b0);
      flush();
      check(o_hdr[0] == g && o_keep[0] === 1'b1, "R3", "check-byte bit repaired", o_hdr[0], g);
      check(o_keep[GOOD_RUN] === 1'b0, "R7", "still detecting one cell short",
            64'(o_keep[GOOD_RUN]), 0);
      check(o_hdr[2*GOOD_RUN+1] == g && o_keep[2*GOOD_RUN+1] === 1'b1, "R7",
            "repaired after full clean run", o_hdr[2*GOOD_RUN+1], g);
      check(n_cor == 2 && n_dis == 1, "R7", "repair count", 64'(n_cor), 2);
   endtask

   task automatic test_delineation_loss();
      logic [39:0] g, bad;
      do_reset(2'b00);
      g   = mk_hdr(32'h7777_0000, 0);
      bad = g ^ (40'h1 << 25) ^ (40'h1 << 24);
      for (int i = 0; i < BAD_RUN - 1; i++) send_cell(bad, 8'h70, 1'b0);
      send_cell(g, 8'h71, 1'b0);
      for (int i = 0; i < BAD_RUN - 1; i++) send_cell(bad, 8'h72, 1'b0);
      idle(3);
      check(n_lod == 0, "R8", "broken run gives no pulse", 64'(n_lod), 0);
      send_cell(bad, 8'h73, 1'b0);
      flush();
      check(n_lod == 1, "R8", "pulse at run limit, one cycle", 64'(n_lod), 1);
   endtask

   task automatic test_coset();
      logic [39:0] gc, gp;
      do_reset(2'b10);
      gc = mk_hdr(32'h0101_0100, 1);
      gp = mk_hdr(32'h0101_0100, 0);
      send_cell(gc, 8'h80, 1'b0);
      send_cell(gp, 8'h81, 1'b0);
      flush();
      check(o_keep[0] === 1'b1 && o_hdr[0] == gc, "R9", "coset header accepted", o_hdr[0], gc);
      check(o_keep[1] === 1'b0 && n_dis == 1 && n_cor == 0, "R9", "plain check byte dropped",
            64'(n_dis), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL R10 watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      test_reset();
      test_clean_stream();
      test_single_fix();
      test_multi_drop();
      test_multi_keep();
      test_return_to_correct();
      test_delineation_loss();
      test_coset();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule